// File: doc/BRIEF.md
# Configurable Macrocell Storage Cell

This block is the storage element behind one logic-array output. A configuration word picks one of four behaviours: the data input passes straight through, or it is captured by an edge-triggered D register, or an edge-triggered toggle register, or a level-sensitive latch. The data can come from the logic array's sum-of-products result or, when the cell serves as an input register, from a pin. Two further product terms force the cell high or low at once. Each has its own inversion bit, so the same AND-type term can also act as an OR-type expression.

The cell runs on one fast sampling clock `clk`. The clock for the stored value is chosen from four global clock lines or a per-block product-term clock. It can be inverted before use. The cell samples the chosen line every `clk` cycle and detects its active edge there. Two outputs are provided. `mc_out` is the result with the set, reset and transparent paths applied. `fb_out` is the raw stored bit that goes back into the interconnect.

Top module: `mc_store`

## Requirements
- R1: With `mode` = 0 (pass-through) and no set or reset active, `mc_out` equals the selected data input in the same cycle, and `fb_out` shows that value one `clk` cycle later.
- R2: With `mode` = 1 (D register), the stored bit takes the selected data input at the `clk` rising edge where the chosen clock's active level is first seen high after being seen low. It holds at every other edge, and `mc_out` shows the stored bit.
- R3: With `mode` = 2 (toggle register), an active clock edge inverts the stored bit when the data input is 1 and leaves it unchanged when the data input is 0.
- R4: With `mode` = 3 (latch), `mc_out` follows the data input while the chosen clock is at its active level, and the stored bit follows at each `clk` edge. While the level is inactive, both hold.
- R5: The set term is active when `set_pt` XOR `set_inv` is 1. An active set drives `mc_out` to 1 in the same cycle, in every mode, and makes the stored bit 1 at the next `clk` edge.
- R6: The reset term is active when `rst_pt` XOR `rst_inv` is 1. It drives `mc_out` to 0 at once and clears the stored bit at the next edge. When set and reset are both active, reset wins.
- R7: `clk_sel` values 0 to 3 choose `gclk[clk_sel]`. Value 4 chooses `pt_clk`. Values 5 to 7 choose a constant low line. Lines that are not selected have no effect.
- R8: With `clk_inv` = 1 the chosen line is inverted, so capture happens on its falling edge and the latch is transparent while the line is low.
- R9: With `in_reg` = 1 the data input is `pin_in`; with `in_reg` = 0 it is `sop_in`.
- R10: A low `rst_n` clears the stored bit and the edge history at once, without waiting for a clock edge. `fb_out` always presents the stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gclk | input | 4 | Global clock lines |
| pt_clk | input | 1 | Per-block product-term clock |
| clk_sel | input | 3 | Clock source select (0-3 global, 4 product term) |
| clk_inv | input | 1 | Invert the chosen clock |
| mode | input | 2 | 0 pass, 1 D, 2 toggle, 3 latch |
| sop_in | input | 1 | Sum-of-products data |
| pin_in | input | 1 | Pin data for input-register use |
| in_reg | input | 1 | Select pin data instead of sum-of-products |
| set_pt | input | 1 | Set product term |
| set_inv | input | 1 | Set term polarity |
| rst_pt | input | 1 | Reset product term |
| rst_inv | input | 1 | Reset term polarity |
| mc_out | output | 1 | Macrocell result |
| fb_out | output | 1 | Stored bit fed back to the interconnect |

## Verification
Every cycle, the assertions check these rules: reset wins over set, a forced value reaches the stored bit, the D register holds between edges and captures the pin in input-register use, the toggle register inverts, and a closed latch holds. Only the bench's scenarios can show that a line which is not selected does nothing, that the unused select codes freeze the cell, that inversion moves capture to the falling edge, and that `rst_n` clears the bit with no clock edge.

// File: rtl/mc_store.sv
module mc_store #(
  parameter int NUM_GCLK = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_GCLK-1:0]               gclk,
  input  logic                              pt_clk,
  input  logic [$clog2(NUM_GCLK+1)-1:0]     clk_sel,
  input  logic                              clk_inv,
  input  logic [1:0]                        mode,
  input  logic                              sop_in,
  input  logic                              pin_in,
  input  logic                              in_reg,
  input  logic                              set_pt,
  input  logic                              set_inv,
  input  logic                              rst_pt,
  input  logic                              rst_inv,
  output logic                              mc_out,
  output logic                              fb_out
);

  localparam int SEL_W = $clog2(NUM_GCLK + 1);
  localparam int IDX_W = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1;
  localparam logic [SEL_W-1:0] PT_CODE = SEL_W'(NUM_GCLK);

  localparam logic [1:0] M_PASS = 2'd0;
  localparam logic [1:0] M_DFF  = 2'd1;
  localparam logic [1:0] M_TFF  = 2'd2;
  localparam logic [1:0] M_LAT  = 2'd3;

  logic sel_src, sel_lvl, lvl_q, edge_hit;
  logic d_src, set_act, rst_act, q;

  always_comb begin
    sel_src = 1'b0;
    if (clk_sel < PT_CODE)
      sel_src = gclk[clk_sel[IDX_W-1:0]];
    else if (clk_sel == PT_CODE)
      sel_src = pt_clk;
  end

  assign sel_lvl  = sel_src ^ clk_inv;
  assign edge_hit = sel_lvl & ~lvl_q;
  assign d_src    = in_reg ? pin_in : sop_in;
  assign set_act  = set_pt ^ set_inv;
  assign rst_act  = rst_pt ^ rst_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= sel_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (rst_act) q <= 1'b0;
    else if (set_act) q <= 1'b1;
    else begin
      case (mode)
        M_PASS: q <= d_src;
        M_DFF:  if (edge_hit) q <= d_src;
        M_TFF:  if (edge_hit && d_src) q <= ~q;
        default: if (sel_lvl) q <= d_src;
      endcase
    end
  end

  always_comb begin
    if (rst_act)                          mc_out = 1'b0;
    else if (set_act)                     mc_out = 1'b1;
    else if (mode == M_PASS)              mc_out = d_src;
    else if (mode == M_LAT && sel_lvl)    mc_out = d_src;
    else                                  mc_out = q;
  end

  assign fb_out = q;

  assert_reset_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pt ^ rst_inv) |=> !fb_out);

  assert_set_forces_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_pt ^ set_inv) && !(rst_pt ^ rst_inv)) |=> fb_out);

  assert_dff_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DFF && !edge_hit && !set_act && !rst_act) |=> $stable(fb_out));

  assert_tff_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_TFF && edge_hit && d_src && !set_act && !rst_act)
      |=> fb_out != $past(fb_out));

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_LAT && !sel_lvl && !set_act && !rst_act) |=> $stable(fb_out));

  assert_pin_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DFF && edge_hit && in_reg && !set_act && !rst_act)
      |=> fb_out == $past(pin_in));

endmodule

// File: tb/test_mc_store.sv
`timescale 1ns/1ps
module test_mc_store;
  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] gclk;
  logic pt_clk, clk_inv, sop_in, pin_in, in_reg;
  logic set_pt, set_inv, rst_pt, rst_inv;
  logic [2:0] clk_sel;
  logic [1:0] mode;
  logic mc_out, fb_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mc_store i_mc_store (
    .clk(clk), .rst_n(rst_n), .gclk(gclk), .pt_clk(pt_clk),
    .clk_sel(clk_sel), .clk_inv(clk_inv), .mode(mode),
    .sop_in(sop_in), .pin_in(pin_in), .in_reg(in_reg),
    .set_pt(set_pt), .set_inv(set_inv), .rst_pt(rst_pt), .rst_inv(rst_inv),
    .mc_out(mc_out), .fb_out(fb_out)
  );

  // mode, sel, inv, gclk, pt, in_reg, sop, pin, {sp,si,rp,ri}, {mc,fb}
  localparam int NV = 44;
  localparam logic [19:0] VEC [NV] = '{
    {2'd1,3'd0,1'b0,4'b0000,1'b0,1'b0,1'b1,1'b0,4'b0000,2'b00},
    {2'd1,3'd0,1'b0,4'b0001,1'b0,1'b0,1'b1,1'b0,4'b0000,2'b11},
    {2'd1,3'd0,1'b0,4'b0001,1'b0,1'b0,1'b0,1'b0,4'b0000,2'b11},
    {2'd1,3'd0,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0,4'b0000,2'b11},
    {2'd1,3'd0,1'b0,4'b0001,1'b0,1'b0,1'b0,1'b0,4'b0000,2'b00},
    {2'd1,3'd2,1'b0,4'b0000,1'b0,1'b0,1'b1,1'b0,4'b0000,2'b00},
    {2'd1,3'd2,1'b0,4'b0100,1'b0,1'b0,1'b1,1'b0,4'b0000,2'b11},
    {2'd1,3'd2,1'b0,4'b0001,1'b0,1'b0,1'b0,1'b0,4'b0000,2'b11},
    {2'd1,3'd2,1'b0,4'b0101,1'b0,1'b0,1'b0,1'b0,4'b0000,2'b00},
    {2'd1,3'd4,1'b0,4'b0000,1'b0,1'b0,1'b1,1'b0,4'b0000,2'b00},
    {2'd1,3'd4,1'b0,4'b0000,1'b1,1'b0,1'b1,1'b0,4'b0000,2'b11},
    {2'd1,3'd5,1'b0,4'b1111,1'b1,1'b0,1'b0,1'b0,4'b0000,2'b11},
    {2'd1,3'd5,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0,4'b0000,2'b11},
    {2'd1,3'd0,1'b1,4'b0001,1'b0,1'b0,1'b0,1'b0,4'b0000,2'b11},
    {2'd1,3'd0,1'b1,4'b0000,1'b0,1'b0,1'b0,1'b0,4'b0000,2'b00},
    {2'd1,3'd0,1'b1,4'b0001,1'b0,1'b0,1'b1,1'b0,4'b0000,2'b00},
    {2'd1,3'd0,1'b1,4'b0000,1'b0,1'b0,1'b1,1'b0,4'b0000,2'b11},
    {2'd2,3'd0,1'b0,4'b0000,1'b0,1'b0,1'b1,1'b0,4'b0000,2'b11},
    {2'd2,3'd0,1'b0,4'b0001,1'b0,1'b0,1'b1,1'b0,4'b0000,2'b00},
    {2'd2,3'd0,1'b0,4'b0000,1'b0,1'b0,1'b1,1'b0,4'b0000,2'b00},
    {2'd2,3'd0,1'b0,4'b0001,1'b0,1'b0,1'b1,1'b0,4'b0000,2'b11},
    {2'd2,3'd0,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0,4'b0000,2'b11},
    {2'd2,3'd0,1'b0,4'b0001,1'b0,1'b0,1'b0,1'b0,4'b0000,2'b11},
    {2'd3,3'd0,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0,4'b0000,2'b11},
    {2'd3,3'd0,1'b0,4'b0001,1'b0,1'b0,1'b0,1'b0,4'b0000,2'b00},
    {2'd3,3'd0,1'b0,4'b0001,1'b0,1'b0,1'b1,1'b0,4'b0000,2'b11},
    {2'd3,3'd0,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0,4'b0000,2'b11},
    {2'd3,3'd0,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0,4'b0000,2'b11},
    {2'd0,3'd0,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0,4'b0000,2'b00},
    {2'd0,3'd0,1'b0,4'b0000,1'b0,1'b0,1'b1,1'b0,4'b0000,2'b11},
    {2'd0,3'd0,1'b0,4'b0001,1'b0,1'b0,1'b0,1'b0,4'b0000,2'b00},
    {2'd1,3'd0,1'b0,4'b0000,1'b0,1'b1,1'b0,1'b1,4'b0000,2'b00},
    {2'd1,3'd0,1'b0,4'b0001,1'b0,1'b1,1'b0,1'b1,4'b0000,2'b11},
    {2'd0,3'd0,1'b0,4'b0000,1'b0,1'b1,1'b1,1'b0,4'b0000,2'b00},
    {2'd1,3'd0,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0,4'b1000,2'b11},
    {2'd1,3'd0,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0,4'b1100,2'b11},
    {2'd1,3'd0,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0,4'b0010,2'b00},
    {2'd1,3'd0,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0,4'b0001,2'b00},
    {2'd1,3'd0,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0,4'b1010,2'b00},
    {2'd1,3'd0,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0,4'b0100,2'b11},
    {2'd1,3'd0,1'b0,4'b0001,1'b0,1'b0,1'b0,1'b0,4'b1000,2'b11},
    {2'd1,3'd0,1'b0,4'b0001,1'b0,1'b0,1'b0,1'b0,4'b0000,2'b11},
    {2'd0,3'd0,1'b0,4'b0001,1'b0,1'b0,1'b0,1'b0,4'b1000,2'b11},
    {2'd0,3'd0,1'b0,4'b0001,1'b0,1'b0,1'b1,1'b0,4'b0010,2'b00}
  };

  function automatic string tag_of(int k);
    if (k < 5)  return "R2";
    if (k < 13) return "R7";
    if (k < 17) return "R8";
    if (k < 23) return "R3";
    if (k < 28) return "R4";
    if (k < 31) return "R1";
    if (k < 34) return "R9";
    if (k < 36) return "R5";
    if (k < 39) return "R6";
    if (k < 43) return "R5";
    return "R6";
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic apply(logic [19:0] v);
    mode = v[19:18]; clk_sel = v[17:15]; clk_inv = v[14]; gclk = v[13:10];
    pt_clk = v[9]; in_reg = v[8]; sop_in = v[7]; pin_in = v[6];
    set_pt = v[5]; set_inv = v[4]; rst_pt = v[3]; rst_inv = v[2];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    apply({2'd1,3'd0,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0,4'b0000,2'b00});
    repeat (3) @(negedge clk);
    check("R10", "reset mc_out", mc_out, 1'b0);
    check("R10", "reset fb_out", fb_out, 1'b0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      apply(VEC[k]);
      @(posedge clk);
      @(negedge clk);
      check(tag_of(k), $sformatf("vector %0d mc_out", k), mc_out, VEC[k][1]);
      check(tag_of(k), $sformatf("vector %0d fb_out", k), fb_out, VEC[k][0]);
    end

    // R10: asynchronous clear without a clock edge
    apply({2'd1,3'd0,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0,4'b1000,2'b00});
    @(posedge clk);
    @(negedge clk);
    check("R10", "preset before clear", fb_out, 1'b1);
    set_pt = 1'b0;
    #0.5;
    rst_n = 1'b0;
    #0.5;
    check("R10", "async clear fb_out", fb_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R7: product-term clock ignored when a global line is selected
    apply({2'd1,3'd1,1'b0,4'b0000,1'b1,1'b0,1'b1,1'b0,4'b0000,2'b00});
    @(posedge clk);
    @(negedge clk);
    check("R7", "pt_clk unselected", fb_out, 1'b0);
    gclk = 4'b0010;
    @(posedge clk);
    @(negedge clk);
    check("R7", "gclk1 captures", fb_out, 1'b1);

    finish_run();
  end
endmodule